// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt state of a small peripheral with sixteen byte-wide registers. It holds seven event flags and seven matching enable bits. Event sources in the peripheral (a shift-complete event at flag bit 2, a second timer at bit 5 and a first timer at bit 6) raise their flag with a one-cycle pulse. Read-side logic elsewhere in the peripheral may ask for a flag to be cleared with a one-cycle request.

Software reaches the two registers over a byte bus. The register index is taken from address bits 12:9. Index 13 is the flag register and index 14 is the enable register. A flag write clears the flags it names. An enable write either sets or clears the enable bits it names; bit 7 of the written byte selects which. A single level interrupt line is driven only by the enabled shift-complete and first-timer flags.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enables are 0, a flag read returns 0x00, an enable read returns 0x80 and irqOut is 0.
- R2: The register index is busAddr[12:9]. Index 13 selects the flag register and index 14 selects the enable register. The other address bits are ignored, and writes to any other index change neither register.
- R3: A write to index 13 clears each flag whose data bit (6:0) is 1 and leaves the other flags unchanged.
- R4: A write to index 14 with data bit 7 = 1 ORs data bits 6:0 into the enables.
- R5: A write to index 14 with data bit 7 = 0 clears each enable whose data bit is 1 and leaves the other enables unchanged.
- R6: A read of index 14 returns the enables in bits 6:0 and always returns 1 in bit 7.
- R7: A read of index 13 returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag is both set and enabled, and this includes flag 5.
- R8: irqOut is 1 exactly when flag 2 or flag 6 is both set and enabled. Flag 5 never drives irqOut.
- R9: A pulse on evtSet[k] sets flag k on the next clock edge. The flag stays set until it is cleared.
- R10: A pulse on evtClr[k] clears flag k on the next edge. If evtSet[k] is also high in that cycle, or a bus write clears bit k in that cycle, the set wins.
- R11: A read of any index other than 13 or 14 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 13 | Bus address; bits 12:9 pick the register |
| busWr | input | 1 | Write strobe for one cycle |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register (combinational) |
| evtSet | input | 7 | Per-flag set pulses |
| evtClr | input | 7 | Per-flag clear requests |
| irqOut | output | 1 | Level interrupt |

## Verification
Flags are raised one at a time and together, and every result is read back. This shows whether each source reaches its own bit and no other. The enable register is written with set and clear patterns that overlap. Each pattern is checked at both the summary bit and the interrupt line, which separates flag 5, since it reaches the summary but not the line, from flags 2 and 6. Set-against-clear collisions, both from the request input and from a bus write, show which side wins. Writes to neighbouring indices, and addresses whose low bits are non-zero, show that the decode uses only bits 12:9.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  typedef struct packed {
    logic flagWr;
    logic enSet;
    logic enClr;
    logic rdFlag;
    logic rdEn;
  } strobeT;
endpackage

// File: rtl/irq_flag_decode.sv
module irq_flag_decode
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int IDX_LO   = 9,
  parameter int IDX_W    = 4,
  parameter int FLAG_IDX = 13,
  parameter int EN_IDX   = 14
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              modeBit,
  output strobeT            strobe
);
  logic [IDX_W-1:0] regIdx;
  logic hitFlag, hitEn;

  assign regIdx  = busAddr[IDX_LO +: IDX_W];
  assign hitFlag = (regIdx == IDX_W'(FLAG_IDX));
  assign hitEn   = (regIdx == IDX_W'(EN_IDX));

  always_comb begin
    strobe        = '0;
    strobe.rdFlag = hitFlag;
    strobe.rdEn   = hitEn;
    strobe.flagWr = busWr && hitFlag;
    strobe.enSet  = busWr && hitEn && modeBit;
    strobe.enClr  = busWr && hitEn && !modeBit;
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_flag_pkg::*;
#(
  parameter int FLAG_W = 7,
  parameter logic [FLAG_W-1:0] IRQ_MASK = 7'h44
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [FLAG_W-1:0] wrBits,
  input  logic [FLAG_W-1:0] evtSet,
  input  logic [FLAG_W-1:0] evtClr,
  output logic [FLAG_W-1:0] flagQ,
  output logic [FLAG_W-1:0] enQ,
  output logic [7:0]        rdData,
  output logic              irq
);
  localparam int PAD_W = 8 - FLAG_W - 1;

  logic [FLAG_W-1:0] active;

  for (genvar k = 0; k < FLAG_W; k++) begin : g_bit
    logic clrFlag;
    assign clrFlag = evtClr[k] || (strobe.flagWr && wrBits[k]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagQ[k] <= 1'b0;
        enQ[k]   <= 1'b0;
      end else begin
        if (evtSet[k])    flagQ[k] <= 1'b1;
        else if (clrFlag) flagQ[k] <= 1'b0;
        if (strobe.enSet && wrBits[k])      enQ[k] <= 1'b1;
        else if (strobe.enClr && wrBits[k]) enQ[k] <= 1'b0;
      end
    end
  end

  assign active = flagQ & enQ;
  assign irq    = |(active & IRQ_MASK);

  always_comb begin
    rdData = 8'h00;
    if (strobe.rdFlag)    rdData = {|active, {PAD_W{1'b0}}, flagQ};
    else if (strobe.rdEn) rdData = {1'b1, {PAD_W{1'b0}}, enQ};
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int FLAG_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [FLAG_W-1:0] evtSet,
  input  logic [FLAG_W-1:0] evtClr,
  output logic              irqOut
);
  strobeT strobe;
  logic [FLAG_W-1:0] flagQ, enQ;

  irq_flag_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr), .busWr(busWr), .modeBit(busWdata[7]), .strobe(strobe)
  );

  irq_flag_regs #(.FLAG_W(FLAG_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrBits(busWdata[FLAG_W-1:0]),
    .evtSet(evtSet), .evtClr(evtClr), .flagQ(flagQ), .enQ(enQ),
    .rdData(busRdata), .irq(irqOut)
  );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
  parameter int ADDR_W = 13,
  parameter int FLAG_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busRdata,
  input logic [FLAG_W-1:0] evtSet,
  input logic [FLAG_W-1:0] evtClr,
  input logic              irqOut,
  input logic [FLAG_W-1:0] flagQ,
  input logic [FLAG_W-1:0] enQ
);
  a_r9_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((flagQ & $past(evtSet)) == $past(evtSet)));

  a_r10_clear_request: assert property (@(posedge clk) disable iff (!rstN)
    ((|(evtClr & ~evtSet)) && !busWr) |=> ((flagQ & $past(evtClr & ~evtSet)) == '0));

  a_r8_line_sources: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((flagQ[2] && enQ[2]) || (flagQ[6] && enQ[6])));

  a_r2_enable_bus_only: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> (enQ == $past(enQ)));

  a_r6_enable_read_msb: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[12:9] == 4'd14) |-> busRdata[7]);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (flagQ == '0 && enQ == '0));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.ADDR_W(ADDR_W), .FLAG_W(FLAG_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRdata(busRdata),
  .evtSet(evtSet), .evtClr(evtClr), .irqOut(irqOut), .flagQ(flagQ), .enQ(enQ)
);

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic [12:0] busAddr = '0;
  logic        busWr = 0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [6:0]  evtSet = '0;
  logic [6:0]  evtClr = '0;
  logic        irqOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_flag_ctrl dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .evtSet(evtSet), .evtClr(evtClr), .irqOut(irqOut)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [12:0] addrOf(int idx, logic [8:0] low);
    return {idx[3:0], low};
  endfunction

  task automatic busWrite(int idx, logic [7:0] d, logic [8:0] low = 9'h0);
    @(negedge clk);
    busAddr = addrOf(idx, low); busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic busRead(int idx, output logic [7:0] d, input logic [8:0] low = 9'h0);
    @(negedge clk);
    busAddr = addrOf(idx, low);
    #1 d = busRdata;
  endtask

  task automatic pulse(logic [6:0] s, logic [6:0] c);
    @(negedge clk);
    evtSet = s; evtClr = c;
    @(negedge clk);
    evtSet = '0; evtClr = '0;
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(13, d); check("R1 flag", d, 8'h00);
    busRead(14, d); check("R1 enable", d, 8'h80);
    check("R1 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testSetAndSummary();
    logic [7:0] d;
    pulse(7'h20, 7'h00);
    busRead(13, d); check("R9 timer2 flag", d, 8'h20);
    busWrite(14, 8'hA0);
    busRead(13, d); check("R7 summary via flag5", d, 8'hA0);
    check("R8 flag5 no irq", {7'b0, irqOut}, 8'h00);
    pulse(7'h04, 7'h00);
    busRead(13, d); check("R9 flag2 set", d, 8'hA4);
    check("R8 flag2 disabled", {7'b0, irqOut}, 8'h00);
    busWrite(14, 8'h84);
    check("R8 flag2 enabled", {7'b0, irqOut}, 8'h01);
    busRead(14, d); check("R4 or-set", d, 8'hA4);
  endtask

  task automatic testClears();
    logic [7:0] d;
    busWrite(13, 8'h04);
    busRead(13, d); check("R3 clear bit2", d, 8'hA0);
    check("R8 irq drop", {7'b0, irqOut}, 8'h00);
    busWrite(14, 8'h20);
    busRead(14, d); check("R5 enable clear", d, 8'h84);
    busRead(13, d); check("R7 no summary", d, 8'h20);
    pulse(7'h40, 7'h00);
    busWrite(14, 8'hC0);
    check("R8 timer1 irq", {7'b0, irqOut}, 8'h01);
    pulse(7'h00, 7'h40);
    busRead(13, d); check("R10 request clear", d, 8'h20);
  endtask

  task automatic testCollisions();
    logic [7:0] d;
    pulse(7'h01, 7'h01);
    busRead(13, d); check("R10 set beats request", d, 8'h21);
    @(negedge clk);
    busAddr = addrOf(13, 9'h0); busWdata = 8'h7F; busWr = 1; evtSet = 7'h08;
    @(negedge clk);
    busWr = 0; evtSet = '0;
    busRead(13, d); check("R10 set beats bus clear", d, 8'h08);
  endtask

  task automatic testDecode();
    logic [7:0] d;
    busWrite(12, 8'h7F);
    busWrite(15, 8'hFF);
    busRead(13, d); check("R2 other idx flag", d, 8'h08);
    busRead(14, d); check("R2 other idx enable", d, 8'hC4);
    busWrite(13, 8'h08, 9'h1FF);
    busRead(13, d, 9'h155); check("R2 low bits ignored", d, 8'h00);
    busRead(5, d); check("R11 other read", d, 8'h00);
    busRead(14, d, 9'h0AA); check("R6 msb", d, 8'hC4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testSetAndSummary();
    testClears();
    testCollisions();
    testDecode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule